// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block gathers every interrupt cause of a single UART channel, keeps each one pending until its own clearing action arrives, and presents the most urgent enabled cause as a 6-bit identification code. It also drives an active-high interrupt line. Event inputs are single-cycle pulses. The error flag and the receive-data level are levels. Register-access strobes tell the block when software reads or writes the registers that act as clears.

The flow-control cause is tracked by a small state machine with three states. `XF_IDLE` means nothing is pending. `XF_XOFF` means a flow-stop character was seen. `XF_SPECIAL` means a special character was seen. The transitions are:

- IDLE→XOFF on a flow-stop event. This takes precedence over a special event in the same cycle.
- IDLE→SPECIAL on a special event.
- XOFF→IDLE on a flow-resume event, unless a new flow-stop event arrives in the same cycle.
- SPECIAL→XOFF on a flow-stop event.
- SPECIAL→IDLE on an identification read that reported this cause, unless a new special event arrives in the same cycle.

The other sources are plain set/clear latches. A priority encoder ranks them, and the enables mask them ahead of the encoder.

Top module: `uart_irq_prio`

## Requirements
- R1: Codes are: none 000001, line status 000110, RX timeout 001100, RX data 000100, TX low 000010, modem 000000, flow/special 010000, CTS/RTS drop 100000.
- R2: Priority, highest first: line status, then RX timeout, then RX data, then TX low, then modem, then flow/special, then CTS/RTS drop. RX timeout is reported over RX data when both are pending.
- R3: `src_en` bit i enables a source. The bit order is 0 line, 1 RX timeout, 2 RX data, 3 TX low, 4 modem, 5 flow/special, 6 CTS/RTS. A disabled source is still latched but is neither reported nor signalled. `irq` is high exactly when the code is not 000001. With `src_en` all zero, `irq` stays low.
- R4: Line status is pending while `line_err` is high or a latched overrun remains. The overrun clears on `lsr_rd`.
- R5: An RX timeout pulse latches and clears on `rhr_rd`. The RX data source follows the `rx_ready` level.
- R6: A TX low pulse latches. It clears on `thr_wr`, or on `iir_rd` in a cycle where the code shows 000010.
- R7: Each `modem_delta` bit latches. The modem source is pending while any latched bit is set, and `msr_rd` clears all of them.
- R8: A flow-stop cause clears only on `xon_evt`. `iir_rd` leaves it pending.
- R9: A special-character cause clears on `iir_rd` while the code shows 010000. `xon_evt` leaves it pending.
- R10: A CTS/RTS drop pulse latches and clears on `iir_rd` while the code shows 100000.
- R11: An `iir_rd` clears only the source whose code is shown in that same cycle. Other pending sources are unaffected.
- R12: When a set event and a clear for the same source arrive in the same cycle, the source stays pending.
- R13: After reset nothing is pending, the code is 000001 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 7 | Per-source enable mask |
| line_err | input | 1 | Level: an errored character is held in the RX FIFO |
| overrun_evt | input | 1 | Pulse: receive overrun |
| rx_timeout_evt | input | 1 | Pulse: receive data has gone stale |
| rx_ready | input | 1 | Level: RX data available or above trigger |
| tx_low_evt | input | 1 | Pulse: transmit side fell below trigger or emptied |
| modem_delta | input | 4 | Pulses: modem input change flags |
| xoff_evt | input | 1 | Pulse: flow-stop character detected |
| special_evt | input | 1 | Pulse: special character detected |
| xon_evt | input | 1 | Pulse: flow-resume character detected |
| flow_drop_evt | input | 1 | Pulse: CTS or RTS went inactive |
| iir_rd | input | 1 | Strobe: identification register read |
| thr_wr | input | 1 | Strobe: transmit holding write |
| msr_rd | input | 1 | Strobe: modem status read |
| lsr_rd | input | 1 | Strobe: line status read |
| rhr_rd | input | 1 | Strobe: receive holding read |
| iir_code | output | 6 | Identification code of the top enabled pending source |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can meet in one cycle: a source's clear strobe, and a fresh set event for that same source. The bench provokes this by pulsing `tx_low_evt` together with `thr_wr`, and `flow_drop_evt` together with an `iir_rd` that reports 100000. It then checks that the code still shows the source afterwards, and that a lone clear removes it on the next step. A second overlap, an identification read while two sources are pending, is judged by checking that only the reported one disappears.

// File: rtl/uip_pkg.sv
package uip_pkg;
    localparam int NSRC   = 7;
    localparam int CODE_W = 6;

    typedef enum logic [2:0] {
        S_LINE = 3'd0,
        S_RXTO = 3'd1,
        S_RHR  = 3'd2,
        S_THR  = 3'd3,
        S_MSR  = 3'd4,
        S_XOFF = 3'd5,
        S_FLOW = 3'd6
    } src_e;

    typedef enum logic [1:0] {
        XF_IDLE    = 2'd0,
        XF_XOFF    = 2'd1,
        XF_SPECIAL = 2'd2
    } xf_state_e;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

    function automatic logic [CODE_W-1:0] code_of(input int idx);
        logic [CODE_W-1:0] c;
        case (idx)
            0:       c = 6'b000110;
            1:       c = 6'b001100;
            2:       c = 6'b000100;
            3:       c = 6'b000010;
            4:       c = 6'b000000;
            5:       c = 6'b010000;
            6:       c = 6'b100000;
            default: c = CODE_NONE;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/uip_event_latch.sv
module uip_event_latch #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic         pend
);
    logic [W-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~{W{clr}}) | set;
    end

    assign pend = |flag_q;

    // R12: a set arriving with a clear still leaves the source pending
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> pend);
    // clear with no set empties the latch
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(|set)) |=> !pend);
endmodule

// File: rtl/uip_xoff_fsm.sv
module uip_xoff_fsm
    import uip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xoff_evt,
    input  logic special_evt,
    input  logic xon_evt,
    input  logic ack,
    output logic pend
);
    xf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: begin
                if (xoff_evt)         state_d = XF_XOFF;
                else if (special_evt) state_d = XF_SPECIAL;
            end
            XF_XOFF: begin
                if (xon_evt && !xoff_evt) state_d = XF_IDLE;
            end
            XF_SPECIAL: begin
                if (xoff_evt)                 state_d = XF_XOFF;
                else if (ack && !special_evt) state_d = XF_IDLE;
            end
            default: state_d = XF_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q != XF_IDLE);
    end

    assert_xoff_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XF_XOFF && !xon_evt) |=> (state_q == XF_XOFF));
    assert_special_ignores_xon_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XF_SPECIAL && !ack && !xoff_evt) |=> (state_q == XF_SPECIAL));
endmodule

// File: rtl/uip_prio_enc.sv
module uip_prio_enc
    import uip_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]      req,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        code = CODE_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = code_of(i);
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uip_pkg::*;
#(
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_en,
    input  logic               line_err,
    input  logic               overrun_evt,
    input  logic               rx_timeout_evt,
    input  logic               rx_ready,
    input  logic               tx_low_evt,
    input  logic [DELTA_W-1:0] modem_delta,
    input  logic               xoff_evt,
    input  logic               special_evt,
    input  logic               xon_evt,
    input  logic               flow_drop_evt,
    input  logic               iir_rd,
    input  logic               thr_wr,
    input  logic               msr_rd,
    input  logic               lsr_rd,
    input  logic               rhr_rd,
    output logic [CODE_W-1:0]  iir_code,
    output logic               irq
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] masked;
    logic            ovr_pend;
    logic            ack_thr, ack_xf, ack_flow;

    assign ack_thr  = iir_rd && (iir_code == code_of(int'(S_THR)));
    assign ack_xf   = iir_rd && (iir_code == code_of(int'(S_XOFF)));
    assign ack_flow = iir_rd && (iir_code == code_of(int'(S_FLOW)));

    uip_event_latch #(.W(1)) u_ovr (
        .clk(clk), .rst_n(rst_n), .set(overrun_evt), .clr(lsr_rd), .pend(ovr_pend));
    uip_event_latch #(.W(1)) u_rxto (
        .clk(clk), .rst_n(rst_n), .set(rx_timeout_evt), .clr(rhr_rd), .pend(pend[S_RXTO]));
    uip_event_latch #(.W(1)) u_thr (
        .clk(clk), .rst_n(rst_n), .set(tx_low_evt), .clr(thr_wr || ack_thr), .pend(pend[S_THR]));
    uip_event_latch #(.W(DELTA_W)) u_msr (
        .clk(clk), .rst_n(rst_n), .set(modem_delta), .clr(msr_rd), .pend(pend[S_MSR]));
    uip_event_latch #(.W(1)) u_flow (
        .clk(clk), .rst_n(rst_n), .set(flow_drop_evt), .clr(ack_flow), .pend(pend[S_FLOW]));

    uip_xoff_fsm u_xf (
        .clk(clk), .rst_n(rst_n), .xoff_evt(xoff_evt), .special_evt(special_evt),
        .xon_evt(xon_evt), .ack(ack_xf), .pend(pend[S_XOFF]));

    assign pend[S_LINE] = line_err || ovr_pend;
    assign pend[S_RHR]  = rx_ready;

    assign masked = pend & src_en;

    uip_prio_enc #(.N(NSRC)) u_enc (.req(masked), .code(iir_code));

    assign irq = |masked;

    assert_pin_code_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_code != CODE_NONE));
    assert_polled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0) |-> !irq);
    assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && src_en[S_LINE]) |-> (iir_code == 6'b000110));
    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        iir_code inside {6'b000001, 6'b000110, 6'b001100, 6'b000100,
                         6'b000010, 6'b000000, 6'b010000, 6'b100000});
    assert_modem_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && modem_delta == '0) |=> !pend[S_MSR]);
endmodule

// File: tb/tb_uart_irq_prio.sv
`timescale 1ns/1ps
module tb_uart_irq_prio;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_en = 7'h7f;
    logic       line_err = 0, overrun_evt = 0, rx_timeout_evt = 0, rx_ready = 0;
    logic       tx_low_evt = 0, xoff_evt = 0, special_evt = 0, xon_evt = 0;
    logic       flow_drop_evt = 0, iir_rd = 0, thr_wr = 0, msr_rd = 0, lsr_rd = 0, rhr_rd = 0;
    logic [3:0] modem_delta = 0;
    logic [5:0] iir_code;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [5:0] code;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    uart_irq_prio dut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .line_err(line_err),
        .overrun_evt(overrun_evt), .rx_timeout_evt(rx_timeout_evt), .rx_ready(rx_ready),
        .tx_low_evt(tx_low_evt), .modem_delta(modem_delta), .xoff_evt(xoff_evt),
        .special_evt(special_evt), .xon_evt(xon_evt), .flow_drop_evt(flow_drop_evt),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .msr_rd(msr_rd), .lsr_rd(lsr_rd),
        .rhr_rd(rhr_rd), .iir_code(iir_code), .irq(irq));

    // monitor: pop expectations and compare against the live outputs
    initial begin
        forever begin
            wait (sb.size() > 0);
            begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (iir_code !== e.code || irq !== e.irq) begin
                    failures++;
                    $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
                             e.tag, iir_code, irq, e.code, e.irq);
                end
            end
        end
    end

    task automatic expect_out(input logic [5:0] c, input logic i, input string tag);
        exp_t e;
        e.code = c; e.irq = i; e.tag = tag;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        overrun_evt = 0; rx_timeout_evt = 0; tx_low_evt = 0; modem_delta = 0;
        xoff_evt = 0; special_evt = 0; xon_evt = 0; flow_drop_evt = 0;
        iir_rd = 0; thr_wr = 0; msr_rd = 0; lsr_rd = 0; rhr_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_out(6'b000001, 0, "R13 reset state");

        // R10 / R1 CTS-RTS drop
        flow_drop_evt = 1; tick();
        expect_out(6'b100000, 1, "R10 flow drop latched");
        // R2: flow-stop outranks CTS/RTS
        xoff_evt = 1; tick();
        expect_out(6'b010000, 1, "R2 xoff over flow drop");
        iir_rd = 1; tick();
        expect_out(6'b010000, 1, "R8 iir read keeps xoff");
        xon_evt = 1; tick();
        expect_out(6'b100000, 1, "R8 xon clears xoff");
        iir_rd = 1; tick();
        expect_out(6'b000001, 0, "R10 iir read clears flow drop");

        // R7 modem
        modem_delta = 4'b0100; tick();
        modem_delta = 4'b0001; tick();
        expect_out(6'b000000, 1, "R7 modem pending");
        iir_rd = 1; tick();
        expect_out(6'b000000, 1, "R11 iir read leaves modem");
        msr_rd = 1; tick();
        expect_out(6'b000001, 0, "R7 msr read clears modem");

        // R6 TX low
        tx_low_evt = 1; tick();
        expect_out(6'b000010, 1, "R6 tx low pending");
        thr_wr = 1; tick();
        expect_out(6'b000001, 0, "R6 thr write clears");
        tx_low_evt = 1; tick();
        iir_rd = 1; tick();
        expect_out(6'b000001, 0, "R6 iir read clears tx low");

        // R5 / R2 receive sources
        rx_ready = 1; tick();
        expect_out(6'b000100, 1, "R5 rx data level");
        rx_timeout_evt = 1; tick();
        expect_out(6'b001100, 1, "R2 timeout over rx data");
        rhr_rd = 1; tick();
        expect_out(6'b000100, 1, "R5 rhr read clears timeout");

        // R4 line status
        line_err = 1; tick();
        expect_out(6'b000110, 1, "R4 line error level top");
        line_err = 0; rx_ready = 0; tick();
        expect_out(6'b000001, 0, "R4 level drop clears");
        overrun_evt = 1; tick();
        expect_out(6'b000110, 1, "R4 overrun latched");
        lsr_rd = 1; tick();
        expect_out(6'b000001, 0, "R4 lsr read clears overrun");

        // R12 set and clear collide
        tx_low_evt = 1; tick();
        tx_low_evt = 1; thr_wr = 1; tick();
        expect_out(6'b000010, 1, "R12 tx set wins over thr write");
        thr_wr = 1; tick();
        expect_out(6'b000001, 0, "R12 lone thr write clears");
        flow_drop_evt = 1; tick();
        flow_drop_evt = 1; iir_rd = 1; tick();
        expect_out(6'b100000, 1, "R12 flow set wins over iir read");
        iir_rd = 1; tick();
        expect_out(6'b000001, 0, "R12 lone iir read clears flow");

        // R3 masking
        src_en = 7'h00; flow_drop_evt = 1; tick();
        expect_out(6'b000001, 0, "R3 polled mode quiet");
        src_en = 7'b1000000; line_err = 1; tick();
        expect_out(6'b100000, 1, "R3 masked line error hidden");
        iir_rd = 1; tick();
        expect_out(6'b000001, 0, "R3 enabled flow cleared");
        line_err = 0; src_en = 7'h7f; tick();

        // R9 special character
        special_evt = 1; tick();
        expect_out(6'b010000, 1, "R9 special pending");
        xon_evt = 1; tick();
        expect_out(6'b010000, 1, "R9 xon ignored for special");
        iir_rd = 1; tick();
        expect_out(6'b000001, 0, "R9 iir read clears special");

        // R11 selective clear
        flow_drop_evt = 1; tx_low_evt = 1; tick();
        expect_out(6'b000010, 1, "R11 tx low shown first");
        iir_rd = 1; tick();
        expect_out(6'b100000, 1, "R11 only tx low cleared");
        iir_rd = 1; tick();
        expect_out(6'b000001, 0, "R11 flow cleared next");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule